// File: doc/BRIEF.md
# Converter Power-Mode Sequencer

This block is a host-side master that drives the chip-select and serial-clock lines of a two-wire-plus-select serial converter, so that the converter can be moved between its operating state and two low-power states. Software, or a higher-level controller, posts one command at a time on a valid/ready port. The command can be a normal conversion, a light sleep, a deep sleep or a wake-up. The sequencer turns each command into the right waveform. A normal frame runs the complete set of clock cycles. Sleep frames are cut short by raising chip-select early. A wake frame is a full-length dummy frame whose data is thrown away, and it is followed by a wait for the converter's power-up time.

The sequencer keeps its own record of the power state it believes the converter is in, and it drives that record on an output. Every command is planned from that record. A deep-sleep request made while the converter is running is sent as two cut-short frames in a row: the first moves the converter to light sleep and the second to deep sleep. A request that would not change the state sends no frame. When the sequence is over, the sequencer raises a one-cycle done pulse. The serial-clock rate, the chip-select gap between frames and both power-up waits are parameters counted in system-clock cycles.

Top module: `adc_pwr_sequencer`

## Requirements
- R1: After reset, `adc_csn` and `adc_sclk` are high, `cmd_ready` is 1, `busy` and `done` are 0, and `pstate` is 0 (running). The `pstate` encoding is 0 = running, 1 = light sleep, 2 = deep sleep.
- R2: A full-length frame holds `adc_csn` low across exactly FRAME_CLKS (default 14) falling edges of `adc_sclk`. `adc_sclk` is high at every edge of `adc_csn`.
- R3: `cmd_op` encodes the command as 0 = convert, 1 = light sleep, 2 = deep sleep, 3 = wake. A command is taken only in a cycle where both `cmd_valid` and `cmd_ready` are 1. A `cmd_valid` raised while `busy` is 1 is ignored.
- R4: A cut-short frame raises `adc_csn` right after the ABORT_FALLS-th falling edge (default 5, which must lie between 2 and 9). `adc_sclk` returns high at that same moment.
- R5: Light sleep from running sends one cut-short frame and sets `pstate` to 1. Light sleep from either sleep state sends no frame and leaves `pstate` unchanged.
- R6: Deep sleep from running sends two cut-short frames. Deep sleep from light sleep sends one. Both end with `pstate` = 2. Deep sleep from deep sleep sends no frame.
- R7: Convert or wake from light sleep sends one full-length frame and sets `pstate` to 0. In that case `done` rises GAP_CYC + WAKE_LITE_CYC cycles after `adc_csn` rises.
- R8: Convert or wake from deep sleep sends one full-length frame and sets `pstate` to 0. In that case `done` rises GAP_CYC + WAKE_DEEP_CYC cycles after `adc_csn` rises.
- R9: Convert from running sends one full-length frame, and `done` rises GAP_CYC cycles after `adc_csn` rises. Wake from running sends no frame.
- R10: `done` is a single-cycle pulse raised once per command. `busy` is 0 in the `done` cycle, and `cmd_ready` returns in the next cycle.
- R11: Asserting `rst_n` in the middle of a frame drives `adc_csn` and `adc_sclk` high at once and returns `pstate` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Command code (see R3) |
| cmd_ready | output | 1 | Command acknowledge; high while idle |
| adc_csn | output | 1 | Converter chip-select, active low |
| adc_sclk | output | 1 | Converter serial clock, idles high |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |
| pstate | output | 2 | Power state the converter is assumed to be in (see R1) |

## Verification
The assertions rely on the parameters being valid for this block: ABORT_FALLS must lie between 2 and 9, both wait lengths must be at least one cycle, and `cmd_op` must be stable whenever `cmd_valid` is high. The bench stays within these limits. It changes `cmd_op` and `cmd_valid` only on the falling system-clock edge, holds each request for exactly one cycle while the block is idle, and raises the deliberately ignored request only after the first frame has started. It also starts with a reset, and asserts reset again in the middle of a frame, so that the state record returns to running.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    OP_CONV  = 2'd0,
    OP_LITE  = 2'd1,
    OP_DEEP  = 2'd2,
    OP_WAKE  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_LITE = 2'd1,
    PS_DEEP = 2'd2
  } pstate_e;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_SETUP,
    FR_LOW,
    FR_HIGH,
    FR_GAP
  } frame_ph_e;

  typedef enum logic [1:0] {
    CT_IDLE,
    CT_SEND,
    CT_WAIT,
    CT_FIN
  } ctl_e;

endpackage

// File: rtl/pwrseq_frame_engine.sv
module pwrseq_frame_engine
  import pwrseq_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int GAP_CYC     = 8,
  parameter int FRAME_CLKS  = 14,
  parameter int ABORT_FALLS = 5
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic csn_o,
  output logic sclk_o,
  output logic idle_o,
  output logic done_o
);

  localparam int CMAX = (HALF_DIV > GAP_CYC) ? HALF_DIV : GAP_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int FW   = $clog2(FRAME_CLKS + 1);

  frame_ph_e       ph_q, ph_d;
  logic [CW-1:0]   hc_q, hc_d;
  logic [FW-1:0]   fc_q, fc_d;
  logic            abort_q, abort_d;
  logic            csn_q, sclk_q;
  logic            half_end, gap_end;

  assign half_end = (hc_q == CW'(HALF_DIV - 1));
  assign gap_end  = (hc_q == CW'(GAP_CYC - 1));

  always_comb begin
    ph_d    = ph_q;
    hc_d    = hc_q;
    fc_d    = fc_q;
    abort_d = abort_q;
    unique case (ph_q)
      FR_IDLE: begin
        if (start_i) begin
          ph_d    = FR_SETUP;
          hc_d    = '0;
          fc_d    = '0;
          abort_d = abort_i;
        end
      end
      FR_SETUP: begin
        if (half_end) begin
          ph_d = FR_LOW;
          hc_d = '0;
          fc_d = fc_q + 1'b1;
        end else begin
          hc_d = hc_q + 1'b1;
        end
      end
      FR_LOW: begin
        if (half_end) begin
          hc_d = '0;
          if (abort_q && (fc_q == FW'(ABORT_FALLS))) ph_d = FR_GAP;
          else                                       ph_d = FR_HIGH;
        end else begin
          hc_d = hc_q + 1'b1;
        end
      end
      FR_HIGH: begin
        if (half_end) begin
          hc_d = '0;
          if (fc_q == FW'(FRAME_CLKS)) begin
            ph_d = FR_GAP;
          end else begin
            ph_d = FR_LOW;
            fc_d = fc_q + 1'b1;
          end
        end else begin
          hc_d = hc_q + 1'b1;
        end
      end
      FR_GAP: begin
        if (gap_end) begin
          ph_d = FR_IDLE;
          hc_d = '0;
        end else begin
          hc_d = hc_q + 1'b1;
        end
      end
      default: ph_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= FR_IDLE;
      hc_q    <= '0;
      fc_q    <= '0;
      abort_q <= 1'b0;
      csn_q   <= 1'b1;
      sclk_q  <= 1'b1;
    end else begin
      ph_q    <= ph_d;
      hc_q    <= hc_d;
      fc_q    <= fc_d;
      abort_q <= abort_d;
      csn_q   <= (ph_d == FR_IDLE) || (ph_d == FR_GAP);
      sclk_q  <= (ph_d != FR_LOW);
    end
  end

  assign csn_o  = csn_q;
  assign sclk_o = sclk_q;
  assign idle_o = (ph_q == FR_IDLE);
  assign done_o = (ph_q == FR_GAP) && gap_end;

  // R2: a frame never runs past its full clock count
  a_r2_fall_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    !csn_q |-> (fc_q <= FW'(FRAME_CLKS)));

  // R2: a full-length frame ends on exactly FRAME_CLKS falls
  a_r2_full_count: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(csn_q) && !abort_q) |-> (fc_q == FW'(FRAME_CLKS)));

  // R4: a cut-short frame ends inside the allowed edge window
  a_r4_abort_window: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(csn_q) && abort_q) |-> ((fc_q >= FW'(2)) && (fc_q <= FW'(9))));

  // R2: serial clock is high whenever select moves
  a_r2_sclk_high_at_cs: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(csn_q) |-> sclk_q);

endmodule

// File: rtl/pwrseq_wait_timer.sv
module pwrseq_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          expire_o
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (load_i) begin
      cnt_d = len_i - 1'b1;
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign expire_o = run_q && (cnt_q == '0);

  // R7: a wait of zero cycles is never requested
  a_r7_len_nonzero: assert property (@(posedge clk) disable iff (!rst_ni)
    load_i |-> (len_i != '0));

  // R8: each wait expires exactly once
  a_r8_single_expire: assert property (@(posedge clk) disable iff (!rst_ni)
    expire_o |=> !expire_o);

endmodule

// File: rtl/adc_pwr_sequencer.sv
module adc_pwr_sequencer
  import pwrseq_pkg::*;
#(
  parameter int HALF_DIV      = 4,
  parameter int GAP_CYC       = 8,
  parameter int FRAME_CLKS    = 14,
  parameter int ABORT_FALLS   = 5,
  parameter int WAKE_LITE_CYC = 256,
  parameter int WAKE_DEEP_CYC = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       cmd_ready,
  output logic       adc_csn,
  output logic       adc_sclk,
  output logic       busy,
  output logic       done,
  output logic [1:0] pstate
);

  localparam int WMAX = (WAKE_LITE_CYC > WAKE_DEEP_CYC) ? WAKE_LITE_CYC : WAKE_DEEP_CYC;
  localparam int TW   = $clog2(WMAX + 1);

  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  ctl_e          ct_q, ct_d;
  pstate_e       ps_q, ps_d;
  logic [1:0]    left_q, left_d;
  logic          abort_q, abort_d;
  logic          start_q, start_d;
  logic          tload;
  logic [TW-1:0] tlen;
  logic          fr_idle, fr_done, t_expire;
  logic          accept;
  logic [1:0]    plan_n;
  logic          plan_abort;
  op_e           op;

  assign op     = op_e'(cmd_op);
  assign accept = cmd_valid && (ct_q == CT_IDLE);

  always_comb begin
    plan_n     = 2'd0;
    plan_abort = 1'b0;
    unique case (op)
      OP_CONV: plan_n = 2'd1;
      OP_WAKE: plan_n = (ps_q == PS_RUN) ? 2'd0 : 2'd1;
      OP_LITE: begin
        plan_abort = 1'b1;
        plan_n     = (ps_q == PS_RUN) ? 2'd1 : 2'd0;
      end
      OP_DEEP: begin
        plan_abort = 1'b1;
        unique case (ps_q)
          PS_RUN:  plan_n = 2'd2;
          PS_LITE: plan_n = 2'd1;
          default: plan_n = 2'd0;
        endcase
      end
      default: plan_n = 2'd0;
    endcase
  end

  always_comb begin
    ct_d    = ct_q;
    ps_d    = ps_q;
    left_d  = left_q;
    abort_d = abort_q;
    start_d = 1'b0;
    tload   = 1'b0;
    tlen    = TW'(WAKE_LITE_CYC);
    unique case (ct_q)
      CT_IDLE: begin
        if (accept) begin
          if (plan_n == 2'd0) begin
            ct_d = CT_FIN;
          end else begin
            left_d  = plan_n;
            abort_d = plan_abort;
            start_d = 1'b1;
            ct_d    = CT_SEND;
          end
        end
      end
      CT_SEND: begin
        if (fr_done) begin
          left_d = left_q - 1'b1;
          if (abort_q) ps_d = (ps_q == PS_RUN) ? PS_LITE : PS_DEEP;
          else         ps_d = PS_RUN;
          if (left_q > 2'd1) begin
            start_d = 1'b1;
          end else if (!abort_q && (ps_q != PS_RUN)) begin
            tload = 1'b1;
            tlen  = (ps_q == PS_LITE) ? TW'(WAKE_LITE_CYC) : TW'(WAKE_DEEP_CYC);
            ct_d  = CT_WAIT;
          end else begin
            ct_d = CT_FIN;
          end
        end
      end
      CT_WAIT: begin
        if (t_expire) ct_d = CT_FIN;
      end
      CT_FIN:  ct_d = CT_IDLE;
      default: ct_d = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ct_q    <= CT_IDLE;
      ps_q    <= PS_RUN;
      left_q  <= 2'd0;
      abort_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      ct_q    <= ct_d;
      ps_q    <= ps_d;
      left_q  <= left_d;
      abort_q <= abort_d;
      start_q <= start_d;
    end
  end

  pwrseq_frame_engine #(
    .HALF_DIV    (HALF_DIV),
    .GAP_CYC     (GAP_CYC),
    .FRAME_CLKS  (FRAME_CLKS),
    .ABORT_FALLS (ABORT_FALLS)
  ) frame_i (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .start_i (start_q),
    .abort_i (abort_q),
    .csn_o   (adc_csn),
    .sclk_o  (adc_sclk),
    .idle_o  (fr_idle),
    .done_o  (fr_done)
  );

  pwrseq_wait_timer #(
    .TW (TW)
  ) timer_i (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .load_i   (tload),
    .len_i    (tlen),
    .expire_o (t_expire)
  );

  assign cmd_ready = (ct_q == CT_IDLE);
  assign busy      = (ct_q == CT_SEND) || (ct_q == CT_WAIT);
  assign done      = (ct_q == CT_FIN);
  assign pstate    = ps_q;

  // R10: done lasts a single cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  // R3: the acknowledge is never offered during a sequence
  a_r3_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_ready |-> !busy);

  // R6: the state record moves only when a frame has finished
  a_r6_pstate_on_frame: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(ps_q) |-> $past(fr_done));

  // R10: a new frame starts only on an idle engine
  a_r10_start_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_q |-> fr_idle);

  // R5: select is released whenever a command can be taken
  a_r5_cs_high_when_ready: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_ready |-> adc_csn);

endmodule

// File: tb/adc_pwr_sequencer_tb_top.sv
module adc_pwr_sequencer_tb_top;

  localparam int HALF = 2;
  localparam int GAP  = 3;
  localparam int TL   = 40;
  localparam int TD   = 100;

  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_op;
  logic       cmd_ready, adc_csn, adc_sclk, busy, done;
  logic [1:0] pstate;

  int total = 0;
  int bad   = 0;

  adc_pwr_sequencer #(
    .HALF_DIV      (HALF),
    .GAP_CYC       (GAP),
    .FRAME_CLKS    (14),
    .ABORT_FALLS   (5),
    .WAKE_LITE_CYC (TL),
    .WAKE_DEEP_CYC (TD)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ready (cmd_ready),
    .adc_csn   (adc_csn),
    .adc_sclk  (adc_sclk),
    .busy      (busy),
    .done      (done),
    .pstate    (pstate)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [1:0] op;
    logic [1:0] nfr;
    logic [4:0] falls;
    logic [1:0] ps;
    logic [7:0] dly;
  } vec_t;

  // dly = 0 means the delay is not checked
  localparam vec_t VECS [13] = '{
    '{2'd0, 2'd1, 5'd14, 2'd0, 8'd3},    // R9 convert from running
    '{2'd1, 2'd1, 5'd5,  2'd1, 8'd3},    // R5 light sleep
    '{2'd1, 2'd0, 5'd0,  2'd1, 8'd0},    // R5 light sleep again: no frame
    '{2'd3, 2'd1, 5'd14, 2'd0, 8'd43},   // R7 wake from light
    '{2'd3, 2'd0, 5'd0,  2'd0, 8'd0},    // R9 wake while running
    '{2'd2, 2'd2, 5'd5,  2'd2, 8'd3},    // R6 deep from running
    '{2'd2, 2'd0, 5'd0,  2'd2, 8'd0},    // R6 deep from deep
    '{2'd1, 2'd0, 5'd0,  2'd2, 8'd0},    // R5 light from deep
    '{2'd0, 2'd1, 5'd14, 2'd0, 8'd103},  // R8 convert from deep
    '{2'd1, 2'd1, 5'd5,  2'd1, 8'd3},    // R5
    '{2'd2, 2'd1, 5'd5,  2'd2, 8'd3},    // R6 deep from light
    '{2'd3, 2'd1, 5'd14, 2'd0, 8'd103},  // R8 wake from deep
    '{2'd0, 2'd1, 5'd14, 2'd0, 8'd3}     // R2 plain convert
  };

  function automatic string tag_of(input logic [1:0] op);
    case (op)
      2'd1:    return "R4 R5";
      2'd2:    return "R4 R6";
      default: return "R2 R7 R8 R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input bit inject, input logic [1:0] inj_op,
                         output int frames, output int fmin, output int fmax, output int dly);
    logic prv_csn, prv_sclk;
    int   falls, cnt, n;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    prv_csn = 1'b1; prv_sclk = 1'b1;
    falls = 0; cnt = 0; n = 0;
    frames = 0; fmin = 99; fmax = 0; dly = 0;
    forever begin
      if (prv_sclk && !adc_sclk && !adc_csn) falls++;
      if (!prv_csn && adc_csn) begin
        frames++;
        if (falls < fmin) fmin = falls;
        if (falls > fmax) fmax = falls;
        falls = 0;
        cnt   = 0;
      end else begin
        cnt++;
      end
      if (done) begin
        dly = cnt;
        check(!busy, "R10 busy at done", int'(busy), 0);
        break;
      end
      if (inject && n == 8) begin
        cmd_valid = 1'b1;
        cmd_op    = inj_op;
      end
      if (inject && n == 9) cmd_valid = 1'b0;
      prv_csn  = adc_csn;
      prv_sclk = adc_sclk;
      n++;
      @(negedge clk);
    end
    @(negedge clk);
    check(!done, "R10 done pulse width", int'(done), 0);
    check(cmd_ready, "R10 ready after done", int'(cmd_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int fr, fmin, fmax, dly;
    bit quiet;
    cmd_valid = 1'b0;
    cmd_op    = 2'd0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(adc_csn,  "R1 csn",   int'(adc_csn), 1);
    check(adc_sclk, "R1 sclk",  int'(adc_sclk), 1);
    check(!busy,    "R1 busy",  int'(busy), 0);
    check(!done,    "R1 done",  int'(done), 0);
    check(pstate == 2'd0, "R1 pstate", int'(pstate), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cmd_ready, "R1 ready", int'(cmd_ready), 1);

    for (int i = 0; i < 13; i++) begin
      run_cmd(VECS[i].op, 1'b0, 2'd0, fr, fmin, fmax, dly);
      check(fr == int'(VECS[i].nfr), {tag_of(VECS[i].op), " frames"}, fr, int'(VECS[i].nfr));
      if (VECS[i].nfr != 2'd0) begin
        check(fmin == int'(VECS[i].falls), {tag_of(VECS[i].op), " falls min"}, fmin, int'(VECS[i].falls));
        check(fmax == int'(VECS[i].falls), {tag_of(VECS[i].op), " falls max"}, fmax, int'(VECS[i].falls));
      end
      check(pstate == VECS[i].ps, {tag_of(VECS[i].op), " pstate"}, int'(pstate), int'(VECS[i].ps));
      if (VECS[i].dly != 8'd0)
        check(dly == int'(VECS[i].dly), {tag_of(VECS[i].op), " done delay"}, dly, int'(VECS[i].dly));
    end

    // R3: a deep-sleep request raised while busy is ignored
    run_cmd(2'd0, 1'b1, 2'd2, fr, fmin, fmax, dly);
    check(fr == 1, "R3 frames with ignored request", fr, 1);
    quiet = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!adc_csn || busy) quiet = 1'b0;
    end
    check(quiet, "R3 no frame from ignored request", int'(quiet), 1);
    check(pstate == 2'd0, "R3 pstate after ignored request", int'(pstate), 0);

    // R11: reset in the middle of a wake frame
    run_cmd(2'd1, 1'b0, 2'd0, fr, fmin, fmax, dly);
    check(pstate == 2'd1, "R11 pre-state light", int'(pstate), 1);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 2'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (12) @(negedge clk);
    check(!adc_csn, "R11 frame in progress", int'(adc_csn), 0);
    rst_n = 1'b0;
    #1;
    check(adc_csn,  "R11 csn on reset",  int'(adc_csn), 1);
    check(adc_sclk, "R11 sclk on reset", int'(adc_sclk), 1);
    check(pstate == 2'd0, "R11 pstate on reset", int'(pstate), 0);
    check(!busy, "R11 busy on reset", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_cmd(2'd0, 1'b0, 2'd0, fr, fmin, fmax, dly);
    check(fr == 1 && fmax == 14, "R2 convert after reset", fmax, 14);
    check(dly == GAP, "R9 delay after reset", dly, GAP);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule